// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into start/stop framed serial characters on one output line. A holding register receives each byte from the processor, and a separate frame register shifts it out. Because the two are decoupled, software can supply the next byte while the current one is still on the wire. The transmitter looks at the holding register again while the final stop bit goes out, so a byte written in time follows with no idle gap.

Frame options are set through a control register: seven or eight data bits, an optional extra bit, and one or two stop bits. The extra bit can be even parity, odd parity, or an address-marker bit whose value comes from a control bit. A programmable divider produces a one-cycle bit tick, and every serial bit lasts exactly one tick period. Two flags report the state of the block. One says the holding register is free. The other says the line has gone quiet after the last stop bit. Each flag has an interrupt line that is the flag gated by an enable.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line output is 1, the holding-empty flag is 1, the end flag is 1, and both interrupt outputs are 0.
- R2: A write to address 0 stores the byte, clears the holding-empty flag and clears the end flag, effective from the next cycle.
- R3: A frame is one 0 start bit, then the data bits LSB first, then the stop bit(s) at 1. Control register (address 1) fields: bit0 seven-bit length, bit1 extra bit present, bit2 extra bit is address marker, bit3 odd parity, bit4 two stop bits, bit5 marker value, bit6 empty-interrupt enable, bit7 end-interrupt enable.
- R4: With bit0 set, only data bits 0 to 6 are sent and bit 7 of the byte is never sent.
- R5: With bit1 set and bit2 clear, the extra bit is the parity over the configured data bits only: even when bit3 is 0, odd when bit3 is 1.
- R6: With bit1 and bit2 set, the extra bit equals control bit5 as it was when the byte moved into the frame register; later changes to bit5 do not affect that frame.
- R7: With bit4 set, two stop bits of 1 are sent.
- R8: Each serial bit lasts divisor+1 clock cycles, where the divisor is written at address 2. A divisor write restarts the divider.
- R9: On the tick that moves a byte into the frame register, the start bit begins and the holding-empty flag becomes 1. The empty interrupt is the flag ANDed with bit6.
- R10: If the holding register is full when the last stop bit begins, that byte is taken and its start bit follows the last stop bit directly, and the end flag stays 0.
- R11: If the holding register is empty when the last stop bit begins, the end flag becomes 1 and the line stays at 1 until the next start bit. The end interrupt is the end flag ANDed with bit7.
- R12: A write while the holding register is already full replaces the pending byte, and only the latest byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 control, 2 divisor |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial line, idles at 1 |
| hold_empty | output | 1 | Holding register free |
| tx_end | output | 1 | Line quiet after last stop bit |
| irq_hold_empty | output | 1 | Holding-empty interrupt level |
| irq_tx_end | output | 1 | End-of-transmission interrupt level |

## Verification
The bench targets the hand-off at the last stop bit. It writes a byte during the previous frame's start bit, and a design that samples the flag at the wrong moment would either insert an idle bit between the two frames or raise the end flag too early. It overwrites a pending byte, which catches a design that queues or drops the later value. It toggles the marker bit in the middle of a frame, which exposes a design that reads the control register live instead of latching it at transfer. It uses seven-bit frames with parity to catch parity taken over all eight bits.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int IDX_W  = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_BAUD = 2'd2;

    // Control register, MSB first
    typedef struct packed {
        logic ie_end;
        logic ie_empty;
        logic mark_val;
        logic two_stop;
        logic odd;
        logic use_mark;
        logic extra_en;
        logic len7;
    } ctrl_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_EXTRA,
        PH_STOP_A,
        PH_STOP_LAST
    } phase_t;

    // Everything a frame needs, frozen at transfer time
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              len7;
        logic              extra_en;
        logic              xbit;
        logic              two_stop;
    } frame_t;

    function automatic logic calc_extra(ctrl_t c, logic [BYTE_W-1:0] d);
        logic p;
        p = c.len7 ? ^d[BYTE_W-2:0] : ^d;
        if (c.use_mark)
            return c.mark_val;
        return c.odd ? ~p : p;
    endfunction

    function automatic frame_t make_frame(ctrl_t c, logic [BYTE_W-1:0] d);
        frame_t f;
        f.data     = d;
        f.len7     = c.len7;
        f.extra_en = c.extra_en;
        f.xbit     = calc_extra(c, d);
        f.two_stop = c.two_stop;
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    input  logic              end_set,
    output logic [BYTE_W-1:0] hold_data,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  divisor,
    output logic              baud_restart,
    output logic              hold_empty,
    output logic              tx_end,
    output logic              irq_hold_empty,
    output logic              irq_tx_end
);

    logic hit_data, hit_ctrl;

    assign hit_data     = wr_en && (wr_addr == ADDR_DATA);
    assign hit_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
    assign baud_restart = wr_en && (wr_addr == ADDR_BAUD);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data  <= '0;
            ctrl       <= '0;
            divisor    <= DIV_W'(DIV_RESET);
            hold_empty <= 1'b1;
            tx_end     <= 1'b1;
        end else begin
            // a processor write wins over a same-cycle transfer
            if (hit_data) begin
                hold_data  <= wr_data;
                hold_empty <= 1'b0;
                tx_end     <= 1'b0;
            end else begin
                if (load)
                    hold_empty <= 1'b1;
                if (end_set)
                    tx_end <= 1'b1;
            end
            if (hit_ctrl)
                ctrl <= ctrl_t'(wr_data);
            if (baud_restart)
                divisor <= DIV_W'(wr_data);
        end
    end

    assign irq_hold_empty = hold_empty && ctrl.ie_empty;
    assign irq_tx_end     = tx_end && ctrl.ie_end;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_empty,
    input  logic [BYTE_W-1:0] hold_data,
    input  ctrl_t             ctrl,
    output logic              load,
    output logic              end_set,
    output logic              txd
);

    phase_t           phase, nxt;
    logic [IDX_W-1:0] bit_idx;
    logic             pend;
    frame_t           fr;
    logic             last_data, entering_last;

    assign last_data = (bit_idx == (fr.len7 ? IDX_W'(BYTE_W-2) : IDX_W'(BYTE_W-1)));

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:      nxt = hold_empty ? PH_IDLE : PH_START;
            PH_START:     nxt = PH_DATA;
            PH_DATA:
                if (last_data)
                    nxt = fr.extra_en ? PH_EXTRA
                                      : (fr.two_stop ? PH_STOP_A : PH_STOP_LAST);
            PH_EXTRA:     nxt = fr.two_stop ? PH_STOP_A : PH_STOP_LAST;
            PH_STOP_A:    nxt = PH_STOP_LAST;
            PH_STOP_LAST: nxt = pend ? PH_START : PH_IDLE;
            default:      nxt = PH_IDLE;
        endcase
    end

    // the holding flag is examined as the final stop bit begins
    assign entering_last = tick && (nxt == PH_STOP_LAST) && (phase != PH_STOP_LAST);
    assign load    = (tick && (phase == PH_IDLE) && !hold_empty)
                   || (entering_last && !hold_empty);
    assign end_set = entering_last && hold_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            pend    <= 1'b0;
            fr      <= '0;
        end else begin
            if (tick) begin
                phase <= nxt;
                if (phase == PH_START)
                    bit_idx <= '0;
                else if (phase == PH_DATA)
                    bit_idx <= bit_idx + 1'b1;
            end
            if (load)
                fr <= make_frame(ctrl, hold_data);
            if (entering_last)
                pend <= !hold_empty;
            else if (tick && phase == PH_STOP_LAST)
                pend <= 1'b0;
        end
    end

    always_comb begin
        unique case (phase)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = fr.data[bit_idx];
            PH_EXTRA: txd = fr.xbit;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_end,
    output logic              irq_hold_empty,
    output logic              irq_tx_end
);

    logic [BYTE_W-1:0] hold_data;
    ctrl_t             ctrl;
    logic [DIV_W-1:0]  divisor;
    logic              baud_restart;
    logic              bit_tick;
    logic              load_pulse;
    logic              end_pulse;

    uart_tx_regs #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .load           (load_pulse),
        .end_set        (end_pulse),
        .hold_data      (hold_data),
        .ctrl           (ctrl),
        .divisor        (divisor),
        .baud_restart   (baud_restart),
        .hold_empty     (hold_empty),
        .tx_end         (tx_end),
        .irq_hold_empty (irq_hold_empty),
        .irq_tx_end     (irq_tx_end)
    );

    uart_tx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (baud_restart),
        .divisor (divisor),
        .tick    (bit_tick)
    );

    uart_tx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_tick),
        .hold_empty (hold_empty),
        .hold_data  (hold_data),
        .ctrl       (ctrl),
        .load       (load_pulse),
        .end_set    (end_pulse),
        .txd        (txd)
    );

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk
    import uart_tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              txd,
    input logic              hold_empty,
    input logic              tx_end,
    input logic              tick,
    input logic              load
);

    logic data_wr;
    assign data_wr = wr_en && (wr_addr == ADDR_DATA);

    AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (!hold_empty && !tx_end)); // R2

    AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load && !data_wr) |=> hold_empty); // R9

    AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        load |-> (tick && !hold_empty)); // R10

    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(tick)); // R8

    AST_END_HOLDS_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> txd); // R11

    AST_END_ONLY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_end) |-> hold_empty); // R11

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_end     (tx_end),
    .tick       (bit_tick),
    .load       (load_pulse)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
    import uart_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       txd, hold_empty, tx_end, irq_hold_empty, irq_tx_end;

    int checks = 0;
    int errors = 0;
    int P = 16;

    always #10 clk = ~clk;

    uart_tx_dbuf dut (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .txd            (txd),
        .hold_empty     (hold_empty),
        .tx_end         (tx_end),
        .irq_hold_empty (irq_hold_empty),
        .irq_tx_end     (irq_tx_end)
    );

    // ctrl[23:16] data[15:8] divisor[7:0]
    localparam logic [23:0] VEC [8] = '{
        24'h00A503, 24'h01D304, 24'h023703, 24'h0A3705,
        24'h038103, 24'h261003, 24'h105A03, 24'h1B0006
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns one negedge later
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic void exp_frame(input logic [7:0] c, input logic [7:0] d,
                                      output logic [15:0] bits, output int n);
        int len;
        logic p;
        bits = '1;
        n = 0;
        len = c[0] ? 7 : 8;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < len; i++) begin bits[n] = d[i]; n++; end
        if (c[1]) begin
            p = c[0] ? ^d[6:0] : ^d;
            bits[n] = c[2] ? c[5] : (c[3] ^ p); n++;
        end
        bits[n] = 1'b1; n++;
        if (c[4]) begin bits[n] = 1'b1; n++; end
    endfunction

    task automatic wait_start();
        while (txd !== 1'b0) @(negedge clk);
    endtask

    task automatic grab(input int n, output logic [15:0] got);
        got = '1;
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (P) @(negedge clk);
            got[i] = txd;
        end
    endtask

    function automatic logic [15:0] msk(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic run_frame(input logic [23:0] v);
        logic [15:0] eb, got;
        int n;
        P = int'(v[7:0]) + 1;
        exp_frame(v[23:16], v[15:8], eb, n);
        wr(ADDR_BAUD, v[7:0]);
        wr(ADDR_CTRL, v[23:16]);
        wr(ADDR_DATA, v[15:8]);
        wait_start();
        repeat (P / 2) @(negedge clk);
        grab(n, got);
        chk("R3 R4 R5 R6 R7 frame bits", 32'(got & msk(n)), 32'(eb & msk(n)));
        chk("R11 end flag at last stop", 32'(tx_end), 32'd1);
        chk("R11 end irq gating", 32'(irq_tx_end), 32'(v[23]));
        repeat (2 * P) @(negedge clk);
        chk("R11 line at mark", 32'(txd), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] a, b, eb;
        int n, len;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 hold_empty", 32'(hold_empty), 32'd1);
        chk("R1 tx_end", 32'(tx_end), 32'd1);
        chk("R1 irqs", 32'({irq_hold_empty, irq_tx_end}), 32'd0);

        // vector table
        for (int v = 0; v < 8; v++) run_frame(VEC[v]);

        // R2 / R8 / R9 / R11 flags, interrupts and bit length
        P = 10;
        wr(ADDR_BAUD, 8'd9);
        wr(ADDR_CTRL, 8'hC0);
        wr(ADDR_DATA, 8'h01);
        chk("R2 hold_empty cleared", 32'(hold_empty), 32'd0);
        chk("R2 tx_end cleared", 32'(tx_end), 32'd0);
        chk("R2 irqs low", 32'({irq_hold_empty, irq_tx_end}), 32'd0);
        while (hold_empty !== 1'b1) @(negedge clk);
        chk("R9 empty irq at transfer", 32'(irq_hold_empty), 32'd1);
        chk("R9 start bit at transfer", 32'(txd), 32'd0);
        len = 0;
        while (txd === 1'b0) begin len++; @(negedge clk); end
        chk("R8 start bit length", 32'(len), 32'(P));
        while (tx_end !== 1'b1) @(negedge clk);
        chk("R11 end irq enabled", 32'(irq_tx_end), 32'd1);
        chk("R11 mark at end", 32'(txd), 32'd1);
        wr(ADDR_CTRL, 8'h00);
        chk("R11 end irq disabled", 32'(irq_tx_end), 32'd0);
        chk("R9 empty irq disabled", 32'(irq_hold_empty), 32'd0);

        // R10 / R12 back-to-back with overwrite of the pending byte
        P = 8;
        wr(ADDR_BAUD, 8'd7);
        wr(ADDR_DATA, 8'h3C);
        wait_start();
        wr(ADDR_DATA, 8'h11);
        wr(ADDR_DATA, 8'hE7);
        chk("R12 pending after overwrite", 32'(hold_empty), 32'd0);
        repeat (P / 2 - 2) @(negedge clk);
        grab(10, a);
        exp_frame(8'h00, 8'h3C, eb, n);
        chk("R10 first frame", 32'(a & msk(n)), 32'(eb & msk(n)));
        chk("R10 no end flag while pending", 32'(tx_end), 32'd0);
        repeat (P) @(negedge clk);
        grab(10, b);
        exp_frame(8'h00, 8'hE7, eb, n);
        chk("R12 second frame is latest byte", 32'(b & msk(n)), 32'(eb & msk(n)));
        chk("R11 end after drain", 32'(tx_end), 32'd1);
        repeat (2 * P) @(negedge clk);

        // R6 marker bit latched at transfer
        P = 4;
        wr(ADDR_BAUD, 8'd3);
        wr(ADDR_CTRL, 8'h26);
        wr(ADDR_DATA, 8'h10);
        wait_start();
        wr(ADDR_CTRL, 8'h06);
        repeat (P / 2 - 1) @(negedge clk);
        exp_frame(8'h26, 8'h10, eb, n);
        grab(n, a);
        chk("R6 marker latched", 32'(a & msk(n)), 32'(eb & msk(n)));
        repeat (2 * P) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule